// File: doc/BRIEF.md
# Incremental Line-Clear Engine

This block keeps the locked-cell bitmap of a falling-block puzzle playfield, 10 columns by 20 rows, and removes every completely filled row. A row counts as filled when the AND of all its cells is 1. The engine does not rebuild the whole board in one cycle. Each filled row costs one update step. In that step the row is dropped, every row above it moves down by one, and the top row refills with empty cells. Each row register gets its own enable and a two-way choice: hold, or take the row above.

A game controller writes a new locked board with a one-cycle load strobe. The engine then walks the board from the bottom row towards the top. At each row index it either removes a filled row and stays at that index, or moves one row up. A clearing flag shows whether any filled row is still on the board, and the controller holds back the next piece spawn while that flag is high. A stable flag reports that the walk has finished. The engine also keeps a count of cleared lines and a score that grows by a fixed number of points per line. Both counts run across loads until reset.

Top module: `line_clear_engine`

## Requirements
- R1: After reset, the board output is all zeros, `stable_o` is 1, `clearing_o` is 0, and both `lines_o` and `score_o` are 0.
- R2: A load strobe places `board_i` on `board_o` at the next clock edge and drops `stable_o` to 0 at that edge.
- R3: A row with any cell at 0 is never removed. While `stable_o` is 1 and no load arrives, the board and the counters hold.
- R4: `clearing_o` is 1 exactly when `board_o` currently holds at least one row whose cells are all 1.
- R5: When the walk ends, the board holds the non-full rows in their original top-to-bottom order, packed against the bottom, with all-zero rows above them.
- R6: Each removed row adds 1 to `lines_o` and `LINE_POINTS` (default 10) to `score_o`, in the same cycle. There is never more than one row per cycle.
- R7: Adjacent full rows are all removed, because the walk examines the same row index again after every removal.
- R8: `stable_o` returns to 1 exactly ROWS + k clock edges after the load edge, where k is the number of full rows. When `stable_o` is 1, `clearing_o` is 0.
- R9: A load during a walk replaces the board and restarts the walk from the bottom row.
- R10: Cell (row r, column c) is bit r*COLS + c of `board_i` and `board_o`. Row 0 is the top row and row ROWS-1 is the bottom row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Strobe that writes `board_i` into the engine |
| board_i | input | ROWS*COLS | Locked board to write, bit r*COLS+c = row r, column c |
| board_o | output | ROWS*COLS | Current board, same bit layout |
| clearing_o | output | 1 | At least one full row remains on the board |
| stable_o | output | 1 | Walk finished, board final |
| lines_o | output | LINES_W | Total cleared lines |
| score_o | output | SCORE_W | Total score |

## Verification
Randomly built boards, in which each row is full about a third of the time and otherwise has at least one hole, are compared against a bench compaction model. These boards show that rows are kept in order and that each removal costs exactly one cycle. Directed boards isolate the edges. An all-full board checks the repeated removal at one index 20 times. A board whose only full row is the top one checks removal of row 0. A board with one almost-full row checks that a single hole protects the row. A load during a walk separates a real restart from a continuation of the old walk.

// File: rtl/line_clear_engine.sv
module line_clear_engine #(
  parameter int COLS        = 10,
  parameter int ROWS        = 20,
  parameter int LINES_W     = 16,
  parameter int SCORE_W     = 20,
  parameter int LINE_POINTS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [ROWS*COLS-1:0] board_i,
  output logic [ROWS*COLS-1:0] board_o,
  output logic                 clearing_o,
  output logic                 stable_o,
  output logic [LINES_W-1:0]   lines_o,
  output logic [SCORE_W-1:0]   score_o
);
  localparam int PTR_W = $clog2(ROWS);

  logic [COLS-1:0]    row_q [ROWS];
  logic [ROWS-1:0]    full;
  logic [ROWS-1:0]    shift_en;
  logic [PTR_W-1:0]   ptr_q;
  logic               busy_q;
  logic [LINES_W-1:0] lines_q;
  logic [SCORE_W-1:0] score_q;
  logic               hit;

  assign hit = busy_q && full[ptr_q];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign full[r]                 = &row_q[r];
    assign shift_en[r]             = hit && (PTR_W'(r) <= ptr_q);
    assign board_o[r*COLS +: COLS] = row_q[r];

    if (r == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n)           row_q[r] <= '0;
        else if (load_i)      row_q[r] <= board_i[r*COLS +: COLS];
        else if (shift_en[r]) row_q[r] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)           row_q[r] <= '0;
        else if (load_i)      row_q[r] <= board_i[r*COLS +: COLS];
        else if (shift_en[r]) row_q[r] <= row_q[r-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      lines_q <= '0;
      score_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      ptr_q  <= PTR_W'(ROWS-1);
    end else if (busy_q) begin
      if (hit) begin
        lines_q <= lines_q + 1'b1;
        score_q <= score_q + SCORE_W'(LINE_POINTS);
      end else if (ptr_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q - 1'b1;
      end
    end
  end

  assign clearing_o = |full;
  assign stable_o   = !busy_q;
  assign lines_o    = lines_q;
  assign score_o    = score_q;

  // R8: a finished walk leaves no full row
  assert_stable_no_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stable_o |-> !clearing_o);

  // R2: loading always starts a walk
  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !stable_o);

  // R3: idle engine holds its board
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_o && !load_i) |=> $stable(board_o));

  // R6: at most one line per cycle, score moves with it
  assert_line_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (lines_o == $past(lines_o)) || (lines_o == $past(lines_o) + 1'b1));

  assert_score_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((lines_o != $past(lines_o)) == (score_o != $past(score_o))));

  // R5: a removal refills the top row with empty cells
  assert_top_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load_i) |=> (board_o[COLS-1:0] == '0));

  // R7: after a removal the same index is examined again
  assert_rescan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load_i) |=> (busy_q && ptr_q == $past(ptr_q)));
endmodule

// File: tb/line_clear_engine_bench.sv
`timescale 1ns/1ps
module line_clear_engine_bench;
  localparam int COLS = 10, ROWS = 20, CELLS = COLS*ROWS;
  localparam int LINES_W = 16, SCORE_W = 20, PTS = 10;

  logic clk = 1'b0, rst_n = 1'b0, load_i = 1'b0;
  logic [CELLS-1:0] board_i = '0, board_o;
  logic clearing_o, stable_o;
  logic [LINES_W-1:0] lines_o;
  logic [SCORE_W-1:0] score_o;

  int checks = 0, failures = 0;
  int exp_lines = 0;

  always #2 clk = ~clk;

  line_clear_engine #(.COLS(COLS), .ROWS(ROWS), .LINES_W(LINES_W),
                      .SCORE_W(SCORE_W), .LINE_POINTS(PTS)) u_line_clear_engine (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .board_i(board_i), .board_o(board_o),
    .clearing_o(clearing_o), .stable_o(stable_o), .lines_o(lines_o), .score_o(score_o));

  task automatic check(input bit ok, input string req, input logic [CELLS-1:0] act,
                       input logic [CELLS-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit any_full(input logic [CELLS-1:0] b);
    for (int r = 0; r < ROWS; r++) if (&b[r*COLS +: COLS]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [CELLS-1:0] compact(input logic [CELLS-1:0] b, output int k);
    logic [CELLS-1:0] o = '0;
    int dst = ROWS-1;
    k = 0;
    for (int src = ROWS-1; src >= 0; src--) begin
      if (&b[src*COLS +: COLS]) k++;
      else begin
        o[dst*COLS +: COLS] = b[src*COLS +: COLS];
        dst--;
      end
    end
    return o;
  endfunction

  function automatic logic [COLS-1:0] rand_row();
    if ($urandom % 3 == 0) return '1;
    return COLS'($urandom) & ~(COLS'(1) << ($urandom % COLS));
  endfunction

  task automatic load(input logic [CELLS-1:0] b);
    @(negedge clk);
    board_i = b;
    load_i  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_i  = 1'b0;
  endtask

  task automatic run_case(input logic [CELLS-1:0] b, input string name);
    int k, n;
    logic [CELLS-1:0] exp_b;
    exp_b = compact(b, k);
    load(b);
    check(board_o == b, {"R2 load ", name}, board_o, b);
    check(!stable_o, {"R2 busy ", name}, CELLS'(stable_o), '0);
    check(clearing_o == any_full(b), {"R4 flag at load ", name},
          CELLS'(clearing_o), CELLS'(any_full(b)));
    n = 0;
    while (!stable_o && n < 4*ROWS) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (clearing_o != any_full(board_o))
        check(1'b0, {"R4 flag during walk ", name}, CELLS'(clearing_o), CELLS'(any_full(board_o)));
    end
    exp_lines += k;
    check(n == ROWS + k, {"R8 latency ", name}, CELLS'(n), CELLS'(ROWS + k));
    check(board_o == exp_b, {"R5 R7 result ", name}, board_o, exp_b);
    check(!clearing_o, {"R8 flag low ", name}, CELLS'(clearing_o), '0);
    check(lines_o == LINES_W'(exp_lines), {"R6 lines ", name}, CELLS'(lines_o), CELLS'(exp_lines));
    check(score_o == SCORE_W'(exp_lines*PTS), {"R6 score ", name}, CELLS'(score_o),
          CELLS'(exp_lines*PTS));
  endtask

  initial begin
    #(200000*4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CELLS-1:0] b, hold_b;
    int k;
    void'($urandom(32'h5EED_0C1E));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(board_o == '0 && stable_o && !clearing_o && lines_o == 0 && score_o == 0,
          "R1 reset state", board_o, '0);

    run_case('0, "empty");
    run_case('1, "all full R7");
    b = '0; b[(ROWS-1)*COLS +: COLS] = '1; b[(ROWS-2)*COLS +: COLS] = 10'h155;
    run_case(b, "bottom full");
    b = '0; b[0 +: COLS] = '1; b[COLS +: COLS] = 10'h3F0;
    run_case(b, "top row R10");
    b = '0; for (int r = 0; r < ROWS; r++) b[r*COLS +: COLS] = 10'h3FE;
    run_case(b, "one hole per row R3");
    b = '0; for (int r = 0; r < ROWS; r++) b[r*COLS +: COLS] = (r % 2) ? '1 : COLS'(r);
    run_case(b, "alternating R7");

    for (int t = 0; t < 200; t++) begin
      for (int r = 0; r < ROWS; r++) b[r*COLS +: COLS] = rand_row();
      run_case(b, "random");
    end

    hold_b = board_o;
    repeat (5) @(negedge clk);
    check(board_o == hold_b && lines_o == LINES_W'(exp_lines), "R3 idle hold", board_o, hold_b);

    b = '0; for (int r = 0; r < ROWS; r++) b[r*COLS +: COLS] = 10'h0F0;
    load(b);
    repeat (3) @(negedge clk);
    check(!stable_o, "R9 still walking", CELLS'(stable_o), '0);
    b = '0; b[(ROWS-3)*COLS +: COLS] = '1; b[(ROWS-1)*COLS +: COLS] = 10'h001;
    void'(compact(b, k));
    run_case(b, "reload R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule